// File: doc/BRIEF.md
# Multi-Phase Edge Quantizer with Third-Order Decimator

This block is the digital back end of an oscillator-based ADC. A ring oscillator supplies one square wave from each of its delay stages. The block samples every phase on each clock and flags any phase whose level differs from the previous sample. Rising and falling transitions count alike. The flags are summed into a small per-sample count. That count is the first-order noise-shaped quantizer output of the converter.

The count feeds a third-order cascaded integrator-comb decimator. The decimator has three integrators running at the sample rate, a down-sampler and three comb stages at the output rate. A run-time select picks a decimation ratio of 256 or 512. Each new 32-bit output word comes with a one-cycle strobe. The first three words after reset carry a settling flag so the consumer can drop them. The integrators are allowed to wrap: the comb differences are exact modulo 2^32, because the largest gain, 11·512³, is below 2^31.

Top module: `vco_edge_decimator`

## Requirements
- R1: An asynchronous active-low reset clears the sampling flops, count register, integrators, combs and decimation counter. While it is low, every output reads zero.
- R2: A phase contributes 1 to a sample when its level at one clock differs from its level at the clock before. This holds for rising and falling transitions alike. A phase that holds its level contributes 0.
- R3: `edge_cnt_o` after clock edge m equals the number of phases whose sample at edge m-1 differs from their sample at edge m-2. The sample before the first edge after reset counts as all zeros, and the value never exceeds 11.
- R4: Call the count after edge j x[j] and define I(m) = Σ x[j]·(m-2-j)(m-1-j)/2 over j ≤ m-2. For a strobe after edge e, take z = I(e-1). `dout_o` equals z_k − 3z_{k-1} + 3z_{k-2} − z_{k-3}, modulo 2^32, with terms before the first output taken as zero.
- R5: `ratio_sel_i` = 1 selects ratio N = 512 and 0 selects N = 256. `dout_valid_o` is high for exactly one cycle per output and is low at all other times.
- R6: The ratio is latched at the first edge after reset and again at each output edge. The first strobe falls at edge N, and each later one falls N edges after the previous, using the N latched at that previous strobe. A change of the select in mid-period has no effect until then.
- R7: `dout_settling_o` is high together with the first three strobes after reset and low on every later strobe.
- R8: When the count is held at a constant c long enough for the window to fill, `dout_o` equals c·N³. Examples: 11·512³, 0, and 256³ for a single toggling phase at N = 256.
- R9: `dout_o` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, also the decimator input rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_i | input | 11 | Ring oscillator phases, one per delay stage |
| ratio_sel_i | input | 1 | Decimation ratio select: 1 = 512, 0 = 256 |
| edge_cnt_o | output | 4 | Per-sample count of phases that changed level |
| dout_o | output | 32 | Decimated output word |
| dout_valid_o | output | 1 | One-cycle strobe marking a new output word |
| dout_settling_o | output | 1 | Set with the first three strobes after reset |

## Verification
The bench drives four stimulus patterns: random toggles, all phases flipping each cycle, frozen phases, and a single phase toggling. It tracks the count and the integrator sums as closed-form weighted windows.

Several corner cases are targeted. An off-by-one in the two-flop sampling would shift every count by a cycle. Missing falling edges would halve the single-phase result. Treating the select as live would move a strobe when the ratio flips mid-period. A wrong integrator width or wrap would break the 11·512³ full-scale word. A mid-run reset then checks that the settling flag restarts and the first strobe again lands at edge N.

// File: rtl/vco_adc_pkg.sv
package vco_adc_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned STAGES = 3;
  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/vco_phase_sampler.sv
module vco_phase_sampler #(
  parameter int unsigned NUM_PHASES = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase_i,
  output logic [NUM_PHASES-1:0] edge_o
);
  logic [NUM_PHASES-1:0] cur_q;
  logic [NUM_PHASES-1:0] old_q;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[g] <= 1'b0;
        old_q[g] <= 1'b0;
      end else begin
        cur_q[g] <= phase_i[g];
        old_q[g] <= cur_q[g];
      end
    end
    assign edge_o[g] = cur_q[g] ^ old_q[g];
  end
endmodule

// File: rtl/vco_edge_adder.sv
module vco_edge_adder #(
  parameter int unsigned NUM_PHASES = 11,
  parameter int unsigned CNT_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] edge_i,
  output logic [CNT_W-1:0]      count_o
);
  logic [CNT_W-1:0] sum_d;
  logic [CNT_W-1:0] sum_q;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < NUM_PHASES; i++) begin
      sum_d = sum_d + CNT_W'(edge_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign count_o = sum_q;
endmodule

// File: rtl/vco_cic_decim.sv
module vco_cic_decim
  import vco_adc_pkg::*;
#(
  parameter int unsigned IN_W     = 4,
  parameter int unsigned RATIO_LO = 256,
  parameter int unsigned RATIO_HI = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] sample_i,
  input  logic            ratio_sel_i,
  output acc_t            data_o,
  output logic            valid_o,
  output logic            settling_o
);
  localparam int unsigned DCNT_W   = $clog2(RATIO_HI);
  localparam int unsigned SETTLE_N = STAGES;
  localparam int unsigned SCNT_W   = $clog2(SETTLE_N + 1);

  acc_t integ_q [STAGES];
  acc_t integ_d [STAGES];
  acc_t dly_q   [STAGES];
  acc_t dly_d   [STAGES];
  acc_t diff    [STAGES];
  acc_t data_q;

  logic [DCNT_W-1:0] dcnt_q, dcnt_d, term;
  logic              ratio_q, ratio_d, primed_q;
  logic              boundary, ratio_ld;
  logic [SCNT_W-1:0] outs_q, outs_d;
  logic              settle_d, settle_q, valid_q;

  // integrators at the input rate, wrapping modulo 2^ACC_W
  always_comb begin
    integ_d[0] = integ_q[0] + ACC_W'(sample_i);
    for (int s = 1; s < STAGES; s++) begin
      integ_d[s] = integ_q[s] + integ_q[s-1];
    end
  end

  // decimation counter and ratio latch
  always_comb begin
    term     = ratio_q ? DCNT_W'(RATIO_HI - 1) : DCNT_W'(RATIO_LO - 1);
    boundary = (dcnt_q == term);
    dcnt_d   = boundary ? '0 : dcnt_q + 1'b1;
    ratio_ld = boundary | ~primed_q;
    ratio_d  = ratio_ld ? ratio_sel_i : ratio_q;
  end

  // comb chain at the output rate
  always_comb begin
    diff[0]  = integ_q[STAGES-1] - dly_q[0];
    dly_d[0] = integ_q[STAGES-1];
    for (int s = 1; s < STAGES; s++) begin
      diff[s]  = diff[s-1] - dly_q[s];
      dly_d[s] = diff[s-1];
    end
  end

  always_comb begin
    settle_d = boundary & (outs_q < SCNT_W'(SETTLE_N));
    outs_d   = settle_d ? outs_q + 1'b1 : outs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        integ_q[s] <= '0;
        dly_q[s]   <= '0;
      end
      data_q   <= '0;
      dcnt_q   <= '0;
      ratio_q  <= 1'b0;
      primed_q <= 1'b0;
      outs_q   <= '0;
      settle_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      integ_q  <= integ_d;
      dcnt_q   <= dcnt_d;
      ratio_q  <= ratio_d;
      primed_q <= 1'b1;
      outs_q   <= outs_d;
      settle_q <= settle_d;
      valid_q  <= boundary;
      if (boundary) begin
        dly_q  <= dly_d;
        data_q <= diff[STAGES-1];
      end
    end
  end

  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign settling_o = settle_q;
endmodule

// File: rtl/vco_edge_decimator.sv
module vco_edge_decimator #(
  parameter int unsigned NUM_PHASES = 11,
  parameter int unsigned RATIO_LO   = 256,
  parameter int unsigned RATIO_HI   = 512,
  localparam int unsigned CNT_W     = $clog2(NUM_PHASES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase_i,
  input  logic                  ratio_sel_i,
  output logic [CNT_W-1:0]      edge_cnt_o,
  output logic [31:0]           dout_o,
  output logic                  dout_valid_o,
  output logic                  dout_settling_o
);
  logic [NUM_PHASES-1:0] edges;

  vco_phase_sampler #(.NUM_PHASES(NUM_PHASES)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase_i),
    .edge_o  (edges)
  );

  vco_edge_adder #(.NUM_PHASES(NUM_PHASES), .CNT_W(CNT_W)) u_adder (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_i  (edges),
    .count_o (edge_cnt_o)
  );

  vco_cic_decim #(.IN_W(CNT_W), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_cic (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (edge_cnt_o),
    .ratio_sel_i (ratio_sel_i),
    .data_o      (dout_o),
    .valid_o     (dout_valid_o),
    .settling_o  (dout_settling_o)
  );
endmodule

// File: rtl/vco_edge_decimator_chk.sv
module vco_edge_decimator_chk #(
  parameter int unsigned NUM_PHASES = 11,
  parameter int unsigned RATIO_LO   = 256,
  parameter int unsigned CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] edge_cnt_o,
  input logic [31:0]      dout_o,
  input logic             dout_valid_o,
  input logic             dout_settling_o
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (dout_valid_o) begin
        gap_q  <= 32'd1;
        seen_q <= 1'b1;
      end else if (gap_q != 32'hFFFF_FFFF) begin
        gap_q <= gap_q + 32'd1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(edge_cnt_o) <= int'(NUM_PHASES)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid_o |=> !dout_valid_o); // R5
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid_o && seen_q) |-> (gap_q >= 32'(RATIO_LO))); // R6
  AST_SETTLE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dout_settling_o |-> dout_valid_o); // R7
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid_o |-> $stable(dout_o)); // R9
endmodule

bind vco_edge_decimator vco_edge_decimator_chk #(
  .NUM_PHASES(NUM_PHASES), .RATIO_LO(RATIO_LO), .CNT_W(CNT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .edge_cnt_o      (edge_cnt_o),
  .dout_o          (dout_o),
  .dout_valid_o    (dout_valid_o),
  .dout_settling_o (dout_settling_o)
);

// File: tb/vco_edge_decimator_bench.sv
module vco_edge_decimator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HIST       = 16384;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] phase_i;
  logic        ratio_sel_i;
  logic [3:0]  edge_cnt_o;
  logic [31:0] dout_o;
  logic        dout_valid_o;
  logic        dout_settling_o;

  vco_edge_decimator u_vco_edge_decimator (
    .clk             (clk),
    .rst_n           (rst_n),
    .phase_i         (phase_i),
    .ratio_sel_i     (ratio_sel_i),
    .edge_cnt_o      (edge_cnt_o),
    .dout_o          (dout_o),
    .dout_valid_o    (dout_valid_o),
    .dout_settling_o (dout_settling_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 0;
  int          m;
  int          mode;
  int          next_b;
  int          nout;
  logic [10:0] ph_drv;
  logic [10:0] p_hist [HIST];
  int          xs     [HIST];
  longint      zh     [4];
  logic [31:0] last_out;

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, m);
    end
  endtask

  function automatic int ratio_of(logic s);
    return s ? 512 : 256;
  endfunction

  // triple-cumulative sum as a closed-form weighted window (R4)
  function automatic longint isum(int mm);
    longint acc = 0;
    for (int j = 1; j <= mm - 2; j++) begin
      acc += longint'(xs[j]) * longint'(mm - 2 - j) * longint'(mm - 1 - j) / 2;
    end
    return acc;
  endfunction

  task automatic bench_reset();
    rst_n = 1'b0;
    phase_i = '0;
    ph_drv = '0;
    #(CLK_PERIOD * 2);
    // R1: all outputs clear while reset is asserted
    check("R1 edge_cnt", edge_cnt_o, 0);
    check("R1 dout", dout_o, 0);
    check("R1 valid", dout_valid_o, 0);
    check("R1 settling", dout_settling_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m = 0; nout = 0; next_b = -1; last_out = '0;
    for (int i = 0; i < 4; i++) zh[i] = 0;
    p_hist[0] = '0;
    xs[0] = 0;
  endtask

  task automatic step();
    logic [10:0] nxt;
    logic        edge_sel;
    longint      v;
    case (mode)
      0:       nxt = ph_drv ^ 11'($urandom());
      1:       nxt = ~ph_drv;
      2:       nxt = ph_drv;
      default: nxt = ph_drv ^ 11'b1;
    endcase
    ph_drv = nxt;
    phase_i = nxt;
    p_hist[m+1] = nxt;
    edge_sel = ratio_sel_i;
    @(posedge clk);
    m++;
    @(negedge clk);
    xs[m] = (m < 2) ? 0 : $countones(p_hist[m-1] ^ p_hist[m-2]);
    check("R3 edge_cnt", edge_cnt_o, xs[m]); // R2 via per-phase XOR
    if (m == 1) next_b = ratio_of(edge_sel);
    check("R5 valid", dout_valid_o, (m == next_b));
    if (m == next_b) begin
      zh[3] = zh[2]; zh[2] = zh[1]; zh[1] = zh[0];
      zh[0] = isum(m - 1);
      v = zh[0] - 3 * zh[1] + 3 * zh[2] - zh[3];
      last_out = v[31:0];
      check("R4 dout", dout_o, last_out);
      check("R7 settling", dout_settling_o, (nout < 3));
      nout++;
      next_b = m + ratio_of(edge_sel);
    end else begin
      check("R9 hold", dout_o, last_out);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    ratio_sel_i = 1'b0;
    mode = 0;
    bench_reset();
    // random toggles at N=256
    run(256 * 8 + 40);
    // R6: select flips mid-period, takes effect at the next strobe
    ratio_sel_i = 1'b1;
    run(512 * 4 + 100);
    // R8: all phases toggle every cycle, N=512
    mode = 1;
    run(512 * 5);
    while (!(m == next_b - 1)) step();
    step();
    check("R8 full scale", dout_o, 64'd11 * 512 * 512 * 512);
    // R2/R8: frozen phases give zero
    ratio_sel_i = 1'b0;
    mode = 2;
    run(512 + 256 * 5);
    while (!(m == next_b - 1)) step();
    step();
    check("R8 still", dout_o, 0);
    // R2/R8: single phase rising and falling every cycle
    mode = 3;
    run(256 * 5);
    while (!(m == next_b - 1)) step();
    step();
    check("R8 one phase", dout_o, 64'd256 * 256 * 256);
    // mid-run reset: R1 and fresh settling (R7)
    @(negedge clk);
    bench_reset();
    mode = 0;
    run(256 * 4 + 10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule